// File: doc/BRIEF.md
# Dual Serial Pattern Detector

This block watches a serial bit stream, one bit per clock, and recognises two fixed bit patterns in it at the same time: `1101` and `11001`, where the leftmost bit is the one received first. Each pattern has its own match flag. The flags come straight from state flops, and each one is high for a single clock cycle.

Internally the block is one Moore machine. Its states record the longest run of recent bits that could still grow into either pattern. Two further states mark a pattern that has just completed. The completion states behave like the "one `1` seen" state, so occurrences that overlap are found. This holds whether the overlapping occurrences are of the same pattern or one of each.

A system uses the block by driving a data bit every cycle and watching the two flags. The reset input clears the machine at once. The block releases it from reset on a clock edge, so bits sampled before the release have no effect.

Top module: `dual_seq_detect`

## Requirements
- R1: While `rst_n` is low, both flags are low. They go low at once when `rst_n` falls, without waiting for a clock edge. After reset is released, bits received before the reset take no part in any later match.
- R2: `hit_a_o` is high for exactly the one clock cycle that starts at the rising edge on which the final bit of `1101` was sampled from `bit_i`. The first `1` is the earliest bit.
- R3: `hit_b_o` is high for exactly the one clock cycle that starts at the rising edge on which the final bit of `11001` was sampled. The first `1` is the earliest bit.
- R4: Overlapping occurrences of one pattern are all reported. The stream `1101101` after reset gives two `hit_a_o` pulses, after the 4th and the 7th bit.
- R5: Occurrences of the two patterns may share bits. The stream `11011001` after reset gives one `hit_a_o` pulse after bit 4 and one `hit_b_o` pulse after bit 8.
- R6: `hit_a_o` and `hit_b_o` are never high in the same cycle.
- R7: The stream `00010110001110111001101101011001011001100111` produces, cycle for cycle, the flags that a direct comparison of the last four and last five received bits gives.
- R8: Streams that contain neither pattern keep both flags low. Examples are all ones, all zeros and alternating bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `bit_i` is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge |
| bit_i | input | 1 | Serial data bit, one per clock |
| hit_a_o | output | 1 | High for one cycle after `1101` completes |
| hit_b_o | output | 1 | High for one cycle after `11001` completes |

## Verification
The bench drives several kinds of stream. Back-to-back `1101` runs test whether a completed match correctly keeps its trailing `1`. A `1101` that runs on into `11001` tests whether the two patterns can share bits. The long mixed stream exercises both patterns with near misses such as `1100` followed by `0`. Streams of all ones, all zeros and alternating bits must leave both flags low, which catches transitions that fall back to the wrong state. A reset applied while a flag is high, and again in the middle of a prefix, shows that the flag clears without waiting for a clock edge and that the partial prefix is forgotten.

// File: rtl/dsd_pkg.sv
package dsd_pkg;

  // One-hot state bit positions of the detector.
  localparam int ST_NONE  = 0;  // no useful suffix
  localparam int ST_1     = 1;  // suffix "1"
  localparam int ST_11    = 2;  // suffix "11"
  localparam int ST_110   = 3;  // suffix "110" (shared prefix)
  localparam int ST_1100  = 4;  // suffix "1100"
  localparam int ST_HIT_A = 5;  // "1101" just completed
  localparam int ST_HIT_B = 6;  // "11001" just completed
  localparam int NUM_ST   = 7;

  typedef logic [NUM_ST-1:0] dsd_state_t;

  localparam dsd_state_t RESET_STATE = dsd_state_t'(1) << ST_NONE;

endpackage

// File: rtl/dsd_rst_sync.sv
module dsd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  // Assert immediately, release after STAGES rising edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dsd_next_state.sv
module dsd_next_state
  import dsd_pkg::*;
(
  input  dsd_state_t st_q,
  input  logic       bit_i,
  output dsd_state_t st_d
);

  logic like_one;  // states whose retained suffix is a single "1"

  always_comb begin
    like_one = st_q[ST_1] | st_q[ST_HIT_A] | st_q[ST_HIT_B];
    st_d     = '0;
    st_d[ST_NONE]  = !bit_i & (st_q[ST_NONE] | st_q[ST_1100] | like_one);
    st_d[ST_1]     =  bit_i &  st_q[ST_NONE];
    st_d[ST_11]    =  bit_i & (st_q[ST_11] | like_one);
    st_d[ST_110]   = !bit_i &  st_q[ST_11];
    st_d[ST_1100]  = !bit_i &  st_q[ST_110];
    st_d[ST_HIT_A] =  bit_i &  st_q[ST_110];
    st_d[ST_HIT_B] =  bit_i &  st_q[ST_1100];
  end

endmodule

// File: rtl/dsd_state_reg.sv
module dsd_state_reg
  import dsd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sync_n,
  input  dsd_state_t st_d,
  output dsd_state_t st_q
);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) st_q <= RESET_STATE;
    else             st_q <= st_d;
  end

  // R6 relies on exactly one state being active at every edge.
  a_r6_onehot_state: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot(st_q))
    else $error("state vector not one-hot");

endmodule

// File: rtl/dual_seq_detect.sv
module dual_seq_detect
  import dsd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  output logic hit_a_o,
  output logic hit_b_o
);

  logic       rst_sync_n;
  dsd_state_t st_q;
  dsd_state_t st_d;

  dsd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dsd_next_state u_next (
    .st_q  (st_q),
    .bit_i (bit_i),
    .st_d  (st_d)
  );

  dsd_state_reg u_reg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .st_d       (st_d),
    .st_q       (st_q)
  );

  // Moore outputs: the terminal state flops drive the pins directly.
  assign hit_a_o = st_q[ST_HIT_A];
  assign hit_b_o = st_q[ST_HIT_B];

  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(hit_a_o && hit_b_o))
    else $error("both flags high");

  a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_a_o |=> !hit_a_o)
    else $error("hit_a longer than one cycle");

  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_b_o |=> !hit_b_o)
    else $error("hit_b longer than one cycle");

  a_r2_last_bit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hit_a_o) |-> $past(bit_i) && $past(st_q[ST_110]))
    else $error("hit_a without 110 followed by 1");

  a_r3_last_bit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(hit_b_o) |-> $past(bit_i) && $past(st_q[ST_1100]))
    else $error("hit_b without 1100 followed by 1");

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !hit_a_o && !hit_b_o)
    else $error("flag high during reset");

endmodule

// File: tb/tb_dual_seq_detect.sv
module tb_dual_seq_detect;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic bit_i;
  logic hit_a_o, hit_b_o;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses_a = 0;
  int pulses_b = 0;
  bit done     = 0;
  logic [4:0] hist;  // reference history of received bits, newest in bit 0

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_seq_detect #(.SYNC_STAGES(SYNC)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_i   (bit_i),
    .hit_a_o (hit_a_o),
    .hit_b_o (hit_b_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one bit after a falling edge; compare at the next falling edge.
  task automatic step(input logic b, input string tag);
    logic ea, eb;
    bit_i = b;
    @(posedge clk);
    hist = {hist[3:0], b};
    @(negedge clk);
    ea = (hist[3:0] == 4'b1101);
    eb = (hist == 5'b11001);
    check({tag, "/R2 hit_a"}, hit_a_o, ea);
    check({tag, "/R3 hit_b"}, hit_b_o, eb);
    check({tag, "/R6 exclusive"}, hit_a_o & hit_b_o, 1'b0);
    if (hit_a_o) pulses_a++;
    if (hit_b_o) pulses_b++;
  endtask

  task automatic send(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) step(s[i] == 8'h31, tag);
  endtask

  // Reset asserted away from any edge, released at a falling edge.
  task automatic do_reset();
    bit_i = 1'b0;
    #1 rst_n = 1'b0;
    #1;
    check("R1 async clear a", hit_a_o, 1'b0);
    check("R1 async clear b", hit_b_o, 1'b0);
    repeat (2) @(negedge clk);
    check("R1 hold a", hit_a_o, 1'b0);
    check("R1 hold b", hit_b_o, 1'b0);
    rst_n = 1'b1;
    repeat (SYNC + 1) @(negedge clk);
    hist = '0;
    pulses_a = 0;
    pulses_b = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    bit_i = 1'b0;
    hist  = '0;
    @(negedge clk);
    check("R1 reset state a", hit_a_o, 1'b0);
    check("R1 reset state b", hit_b_o, 1'b0);
    do_reset();

    // R4: self-overlap of 1101
    send("1101101", "R4");
    check("R4 pulse count a", logic'(pulses_a == 2), 1'b1);
    check("R4 pulse count b", logic'(pulses_b == 0), 1'b1);

    // R5: 1101 sharing bits with 11001
    do_reset();
    send("11011001", "R5");
    check("R5 pulse count a", logic'(pulses_a == 1), 1'b1);
    check("R5 pulse count b", logic'(pulses_b == 1), 1'b1);

    // R1: reset while hit_a is high clears it at once
    do_reset();
    send("1101", "R1");
    check("R1 flag before reset", hit_a_o, 1'b1);
    do_reset();

    // R1: a prefix 110 broken by reset does not complete afterwards
    send("110", "R1");
    do_reset();
    send("1", "R1");
    check("R1 prefix forgotten", hit_a_o, 1'b0);

    // R7: reference stream
    do_reset();
    send("00010110001110111001101101011001011001100111", "R7");

    // R8: streams without either pattern
    do_reset();
    send("1111111111", "R8");
    send("0000000000", "R8");
    send("1010101010", "R8");
    check("R8 no pulses a", logic'(pulses_a == 0), 1'b1);
    check("R8 no pulses b", logic'(pulses_b == 0), 1'b1);

    // Mixed overlaps on both patterns
    do_reset();
    send("110011001101100111001", "R5");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule